// File: doc/BRIEF.md
# Radio Packet Receive Framer

The framer follows one incoming packet on a byte-serial receive path, from the moment the bit-level front end reports a preamble until the last payload byte has been handed to the receive FIFO. When a preamble is reported, the framer takes a snapshot of its configuration. It can then compare a network identifier byte, a node identifier byte, or both, against programmed values. It takes the payload length either from a programmed fixed size or from a length byte that follows the identifiers. It then forwards exactly that many payload bytes to the FIFO write port.

Single-cycle pulses mark the acceptance of a packet and its completion. A separate pulse reports each payload byte that was lost because the FIFO was full. A host stop command or a switch to transmit mode ends reception quietly. A carrier-sense output stays high for a packet that failed identification, for as long as the front end still reports a carrier. CRC bytes that follow the payload are never forwarded. The front end that supplies the bytes, the CRC logic and the FIFO storage sit outside this block.

Top module: `rx_framer`

## Requirements
- R1: `sop_o` pulses for one cycle only after `pre_det_i` has been seen and every enabled identifier byte has matched. With both checks disabled it pulses in the cycle after `pre_det_i`. Otherwise it pulses in the cycle after the last enabled identifier byte. The network byte is checked first and the node byte second.
- R2: In fixed mode (`fixed_mode_i`=1), the packet ends after `fixed_len_i` payload bytes. The bytes that follow, such as CRC bytes, are not written to the FIFO. `eop_o` pulses together with the write of the last payload byte. A fixed size of 0 gives `sop_o` and `eop_o` in the same cycle.
- R3: In variable mode, the first byte after the identifiers is the payload length. This byte is not written to the FIFO. `eop_o` pulses together with the last payload write. A length of 0 gives `eop_o` in the cycle after the length byte, and nothing is written.
- R4: `rx_stop_i` or `tx_mode_i` ends an active packet. No `eop_o` is produced and the framer returns to preamble search. `pre_det_i` is ignored while either input is high.
- R5: A payload byte that arrives while `fifo_full_i` is high is not written. `ovf_o` pulses for it, and the byte still counts toward the packet length.
- R6: An identifier mismatch returns the framer to preamble search. No byte of that packet is written, and `cs_o` goes high. `cs_o` falls in the cycle after `carrier_i` goes low.
- R7: The identifier values, the fixed size and the mode select are sampled in the cycle in which `pre_det_i` is accepted. Later changes to them do not affect the current packet.
- R8: All outputs are registered and respond one cycle after the input byte that causes them. After reset every output is low, and `fifo_data_o` carries the forwarded byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_det_i | input | 1 | Preamble detected pulse from the front end |
| byte_vld_i | input | 1 | Received byte valid |
| byte_i | input | 8 | Received byte |
| carrier_i | input | 1 | Front end reports a carrier on air |
| net_chk_en_i | input | 1 | Enable network identifier check |
| node_chk_en_i | input | 1 | Enable node identifier check |
| net_id_i | input | 8 | Expected network identifier |
| node_id_i | input | 8 | Expected node identifier |
| fixed_mode_i | input | 1 | 1: fixed payload size, 0: length byte in header |
| fixed_len_i | input | 8 | Payload size in fixed mode, CRC excluded |
| rx_stop_i | input | 1 | Host command to stop reception |
| tx_mode_i | input | 1 | Radio is in transmit mode |
| fifo_full_i | input | 1 | Receive FIFO is full |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |
| sop_o | output | 1 | Packet accepted pulse |
| eop_o | output | 1 | Packet complete pulse |
| ovf_o | output | 1 | Payload byte dropped on a full FIFO |
| cs_o | output | 1 | Carrier sense for an unidentified packet |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a packet. It must be shown to have no effect, across every combination of identifier enables and length modes, including the zero-length edge. The bench sweeps every combination of the two identifier enables and both length modes over payload lengths 0 to 3, with and without a full FIFO on the second payload byte. After each accepted preamble, it scrambles the identifier values, the fixed size and the mode select. It then follows each payload with two trailing bytes and one idle cycle, to show that the end of the packet was placed exactly. Separate sequences cover aborts while payload is arriving, a preamble presented during transmit mode, and mismatched identifiers. Each mismatch case is followed by a carrier drop.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    S_HUNT = 3'd0,
    S_NET  = 3'd1,
    S_NODE = 3'd2,
    S_LEN  = 3'd3,
    S_PAY  = 3'd4
  } rxf_state_e;

  localparam int unsigned N_ID = 2;
  localparam int unsigned ID_NET = 0;
  localparam int unsigned ID_NODE = 1;
endpackage

// File: rtl/rxf_id_match.sv
module rxf_id_match #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          en_i,
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] byte_i,
  output logic          en_o,
  output logic          hit_o
);
  logic [DW-1:0] ref_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      en_q  <= 1'b0;
    end else if (load_i) begin
      ref_q <= ref_i;
      en_q  <= en_i;
    end
  end

  assign en_o  = en_q;
  assign hit_o = (byte_i == ref_q);

  // R7: snapshot holds between loads
  p_ref_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ref_q));
endmodule

// File: rtl/rxf_len_ctr.sv
module rxf_len_ctr #(
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] lim_i,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic          zero_o,
  output logic          last_o
);
  localparam int unsigned CW = LW + 1;

  logic [LW-1:0] lim_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lim_q <= '0;
    else if (load_i) lim_q <= lim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign zero_o = (lim_q == '0);
  assign last_o = (CW'(cnt_q) + CW'(1) == CW'(lim_q));

  p_cnt_below_lim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !zero_o) |-> (CW'(cnt_q) < CW'(lim_q)));
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxf_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pre_det_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          carrier_i,
  input  logic          net_chk_en_i,
  input  logic          node_chk_en_i,
  input  logic [DW-1:0] net_id_i,
  input  logic [DW-1:0] node_id_i,
  input  logic          fixed_mode_i,
  input  logic [LW-1:0] fixed_len_i,
  input  logic          rx_stop_i,
  input  logic          tx_mode_i,
  input  logic          fifo_full_i,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          sop_o,
  output logic          eop_o,
  output logic          ovf_o,
  output logic          cs_o
);
  rxf_state_e st_q, st_d;
  logic abort, accept;
  logic fixed_q;
  logic [N_ID-1:0] id_en, id_hit;
  logic [N_ID-1:0] id_en_in;
  logic [DW-1:0] id_ref [N_ID];
  logic lim_zero, lim_last, lim_load, cnt_clr, cnt_inc;
  logic [LW-1:0] lim_val;
  logic sop_d, eop_d, wr_d, ovf_d, mis_d;

  assign abort  = rx_stop_i | tx_mode_i;
  assign accept = (st_q == S_HUNT) && pre_det_i && !abort;

  assign id_en_in[ID_NET]  = net_chk_en_i;
  assign id_en_in[ID_NODE] = node_chk_en_i;
  assign id_ref[ID_NET]    = net_id_i;
  assign id_ref[ID_NODE]   = node_id_i;

  for (genvar g = 0; g < N_ID; g++) begin : g_id
    rxf_id_match #(.DW(DW)) u_id (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(accept),
      .en_i  (id_en_in[g]),
      .ref_i (id_ref[g]),
      .byte_i(byte_i),
      .en_o  (id_en[g]),
      .hit_o (id_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fixed_q <= 1'b0;
    else if (accept) fixed_q <= fixed_mode_i;
  end

  assign lim_load = accept | ((st_q == S_LEN) && byte_vld_i && !abort);
  assign lim_val  = accept ? fixed_len_i : LW'(byte_i);
  assign cnt_clr  = (st_q != S_PAY);
  assign cnt_inc  = (st_q == S_PAY) && byte_vld_i && !abort;

  rxf_len_ctr #(.LW(LW)) u_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(lim_load),
    .lim_i (lim_val),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .zero_o(lim_zero),
    .last_o(lim_last)
  );

  always_comb begin
    st_d  = st_q;
    sop_d = 1'b0;
    eop_d = 1'b0;
    wr_d  = 1'b0;
    ovf_d = 1'b0;
    mis_d = 1'b0;
    if (abort) begin
      st_d = S_HUNT;
    end else begin
      unique case (st_q)
        S_HUNT: if (pre_det_i) begin
          if (net_chk_en_i) st_d = S_NET;
          else if (node_chk_en_i) st_d = S_NODE;
          else begin
            sop_d = 1'b1;
            if (!fixed_mode_i) st_d = S_LEN;
            else if (fixed_len_i == '0) eop_d = 1'b1;
            else st_d = S_PAY;
          end
        end
        S_NET, S_NODE: if (byte_vld_i) begin
          if (!id_hit[(st_q == S_NET) ? ID_NET : ID_NODE]) begin
            st_d  = S_HUNT;
            mis_d = 1'b1;
          end else if (st_q == S_NET && id_en[ID_NODE]) begin
            st_d = S_NODE;
          end else begin
            sop_d = 1'b1;
            if (!fixed_q) st_d = S_LEN;
            else if (lim_zero) begin
              st_d  = S_HUNT;
              eop_d = 1'b1;
            end else st_d = S_PAY;
          end
        end
        S_LEN: if (byte_vld_i) begin
          if (byte_i == '0) begin
            st_d  = S_HUNT;
            eop_d = 1'b1;
          end else st_d = S_PAY;
        end
        S_PAY: if (byte_vld_i) begin
          wr_d  = !fifo_full_i;
          ovf_d = fifo_full_i;
          if (lim_last) begin
            st_d  = S_HUNT;
            eop_d = 1'b1;
          end
        end
        default: st_d = S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_HUNT;
      sop_o       <= 1'b0;
      eop_o       <= 1'b0;
      fifo_wr_o   <= 1'b0;
      ovf_o       <= 1'b0;
      fifo_data_o <= '0;
      cs_o        <= 1'b0;
    end else begin
      st_q      <= st_d;
      sop_o     <= sop_d;
      eop_o     <= eop_d;
      fifo_wr_o <= wr_d;
      ovf_o     <= ovf_d;
      if (wr_d) fifo_data_o <= byte_i;
      if (!carrier_i) cs_o <= 1'b0;
      else if (mis_d) cs_o <= 1'b1;
    end
  end

  p_abort_no_eop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!eop_o && !fifo_wr_o && !sop_o));
  p_full_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && fifo_full_i) |=> !fifo_wr_o);
  p_wr_ovf_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_wr_o && ovf_o));
  p_hunt_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_PAY) |=> !fifo_wr_o);
  p_cs_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_i |=> !cs_o);
  p_sop_from_hunt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_HUNT) && !pre_det_i) |=> !sop_o);
  p_fixed_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(fixed_q));
endmodule

// File: tb/rx_framer_bench.sv
module rx_framer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_det = 0, vld = 0, carrier = 1, net_en = 0, node_en = 0;
  logic fixed_m = 0, stop = 0, txm = 0, full = 0;
  logic [7:0] bt = 0, net_id = 8'h5A, node_id = 8'h3C, flen = 0;
  logic wr, sop, eop, ovf, cs;
  logic [7:0] wdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_framer u_rx_framer (
    .clk_i(clk), .rst_ni(rst_n), .pre_det_i(pre_det), .byte_vld_i(vld), .byte_i(bt),
    .carrier_i(carrier), .net_chk_en_i(net_en), .node_chk_en_i(node_en),
    .net_id_i(net_id), .node_id_i(node_id), .fixed_mode_i(fixed_m), .fixed_len_i(flen),
    .rx_stop_i(stop), .tx_mode_i(txm), .fifo_full_i(full),
    .fifo_wr_o(wr), .fifo_data_o(wdata), .sop_o(sop), .eop_o(eop), .ovf_o(ovf), .cs_o(cs));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic pd);
    @(negedge clk);
    vld = v; bt = b; pre_det = pd;
    @(posedge clk);
    #1;
    vld = 0; pre_det = 0;
  endtask

  task automatic outs(input string req, input int s, input int e, input int w, input int o);
    chk({req, " sop"}, int'(sop), s);
    chk({req, " eop"}, int'(eop), e);
    chk({req, " wr"}, int'(wr), w);
    chk({req, " ovf"}, int'(ovf), o);
  endtask

  // R1 R2 R3 R5 R7 R8: one packet, config scrambled after acceptance
  task automatic run_pkt(input logic ne, input logic nde, input logic fx, input int len, input bit fm);
    bit noid;
    noid = !ne && !nde;
    net_en = ne; node_en = nde; fixed_m = fx; flen = 8'(len);
    net_id = 8'h5A; node_id = 8'h3C;
    step(0, 8'h00, 1);
    outs("R1 pre", int'(noid), int'(noid && fx && len == 0), 0, 0);
    net_id = 8'hFF; node_id = 8'hEE; fixed_m = !fx; flen = 8'd9; // R7
    if (ne) begin
      step(1, 8'h5A, 0);
      outs("R1 net", int'(!nde), int'(!nde && fx && len == 0), 0, 0);
    end
    if (nde) begin
      step(1, 8'h3C, 0);
      outs("R1 node", 1, int'(fx && len == 0), 0, 0);
    end
    if (!fx) begin
      step(1, 8'(len), 0);
      outs("R3 len", 0, int'(len == 0), 0, 0);
    end
    for (int i = 0; i < len; i++) begin
      full = fm && (i == 1);
      step(1, 8'hA0 + 8'(i), 0);
      full = 0;
      outs(fx ? "R2 pay" : "R3 pay", 0, int'(i == len - 1), int'(!(fm && i == 1)), int'(fm && i == 1));
      if (!(fm && i == 1)) chk("R8 data", int'(wdata), 'hA0 + i);
    end
    for (int k = 0; k < 2; k++) begin
      step(1, 8'hC5, 0);
      outs("R2 trail", 0, 0, 0, 0);
    end
    step(0, 8'h00, 0);
    outs("R8 idle", 0, 0, 0, 0);
  endtask

  task automatic mismatch(input logic ne, input logic nde);
    carrier = 1; net_en = ne; node_en = nde; fixed_m = 1; flen = 8'd2;
    net_id = 8'h5A; node_id = 8'h3C;
    step(0, 8'h00, 1);
    if (ne && nde) step(1, 8'h5A, 0);
    step(1, 8'h77, 0);
    outs("R6 mis", 0, 0, 0, 0);
    chk("R6 cs high", int'(cs), 1);
    for (int k = 0; k < 3; k++) begin
      step(1, 8'h11, 0);
      outs("R6 after", 0, 0, 0, 0);
    end
    chk("R6 cs hold", int'(cs), 1);
    carrier = 0;
    step(0, 8'h00, 0);
    chk("R6 cs drop", int'(cs), 0);
    carrier = 1;
  endtask

  task automatic abort_run(input bit use_tx);
    net_en = 0; node_en = 0; fixed_m = 0;
    step(0, 8'h00, 1);
    step(1, 8'd4, 0);
    step(1, 8'hA0, 0);
    step(1, 8'hA1, 0);
    if (use_tx) txm = 1; else stop = 1;
    step(1, 8'hA2, 0);
    outs("R4 abort", 0, 0, 0, 0);
    txm = 0; stop = 0;
    for (int k = 0; k < 3; k++) begin
      step(1, 8'hA3, 0);
      outs("R4 hunt", 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    outs("R8 reset", 0, 0, 0, 0);
    chk("R8 reset cs", int'(cs), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int ne = 0; ne < 2; ne++)
      for (int nd = 0; nd < 2; nd++)
        for (int fx = 0; fx < 2; fx++)
          for (int ln = 0; ln < 4; ln++)
            for (int fm = 0; fm < 2; fm++)
              run_pkt(1'(ne), 1'(nd), 1'(fx), ln, bit'(fm));
    mismatch(1, 0);
    mismatch(0, 1);
    mismatch(1, 1);
    abort_run(0);
    abort_run(1);
    // R4: preamble ignored in transmit mode
    net_en = 0; node_en = 0; fixed_m = 1; flen = 8'd1; txm = 1;
    step(0, 8'h00, 1);
    outs("R4 txpre", 0, 0, 0, 0);
    txm = 0;
    step(1, 8'h42, 0);
    outs("R4 txpre byte", 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule